// File: doc/BRIEF.md
# Compare-Driven Square Wave Generator

This block turns a free-running 16-bit timer into a square wave with a 50 % duty cycle. It holds a compare register. Each time the timer reaches that value, the block inverts its output and moves the compare point forward by the active half-period. Because the new compare is added to the old one, the wave stays locked to the timer and the timer is never reloaded.

A producer delivers half-period updates through a buffered value and a valid flag. The producer lowers the flag while it rewrites the buffer and raises it again when the write is done. The block only adopts the buffered value at a toggle, and only if the flag is high at that moment. A half-written value therefore never reaches the wave.

When the block is enabled, it takes a seed value (the first measured input period) as both the first compare point and the first half-period. A stop request halts toggling and parks the output high, which switches the external driver off. The output stays parked until enable has been removed.

Top module: `sqwave_cmp_gen`

## Requirements
- R1: While running, a cycle where `tick_i` is high and `tmr_i` equals the compare register inverts `wave_o` on the next clock edge.
- R2: After each toggle the compare register becomes the old compare value plus the half-period in force for that toggle, modulo 2^16.
- R3: If `hp_valid_i` is high during a toggle cycle, `hp_buf_i` becomes the active half-period and is the value added to the compare register for that same toggle.
- R4: If `hp_valid_i` is low during a toggle cycle, the active half-period is kept and `hp_buf_i` has no effect, whatever it holds.
- R5: When `en_i` is seen high in the idle state with `stop_i` low, both the compare register and the active half-period load `seed_i`, and `wave_o` stays high until the first match.
- R6: A synchronous reset (`rst_n` low) leaves `wave_o` high and the block idle.
- R7: `stop_i` high drives `wave_o` high on the next edge and ends toggling. The block stays halted, even after `stop_i` falls, until `en_i` has been low for at least one cycle.
- R8: Dropping `en_i` while running drives `wave_o` high on the next edge and returns the block to idle.
- R9: A timer value equal to the compare register has no effect in a cycle where `tick_i` is low, so each timer value gives at most one match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Enable; rising use starts generation from the seed |
| stop_i | input | 1 | Stall stop request; parks the output high |
| tmr_i | input | 16 | Free-running timer value |
| tick_i | input | 1 | High in the cycle where `tmr_i` takes a new value |
| seed_i | input | 16 | First compare point and first half-period |
| hp_buf_i | input | 16 | Buffered next half-period |
| hp_valid_i | input | 1 | Buffered half-period is complete and may be taken |
| wave_o | output | 1 | Square wave output, high when parked |

## Verification
The bench goes after the buffer handover. It rewrites the buffer while the valid flag is low and then raises the flag near toggle points. A design that sampled the buffer without looking at the flag, or that added the old half-period after the swap, would place the next edge at the wrong timer value. A directed case starts near the top of the timer range, so the compare sum wraps; a design that saturated or carried into a wider register would never toggle again.

Another case holds the timer at the compare value with the tick low. A design that matched on level rather than on tick would toggle repeatedly. Stop is raised and dropped while enable stays high, to catch a design that restarts on its own instead of staying parked high.

// File: rtl/sqw_pkg.sv
// Shared types for the square wave generator.
// Assumes nothing beyond a single clock domain.
package sqw_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_HALT = 2'd2
    } sq_state_e;
endpackage

// File: rtl/sqw_match.sv
// Compare detector: flags a hit when the timer has just taken a new value
// equal to the compare point and the generator is armed.
// Assumes tick_i is high for exactly one cycle per timer value.
module sqw_match #(
    parameter int W = 16
) (
    input  logic         armed_i,
    input  logic         tick_i,
    input  logic [W-1:0] tmr_i,
    input  logic [W-1:0] cmp_i,
    output logic         hit_o
);
    // Equality against the timer, qualified by the tick so a value matches once.
    always_comb begin
        hit_o = armed_i && tick_i && (tmr_i == cmp_i);
    end
endmodule

// File: rtl/sqw_period.sv
// Compare point and active half-period registers with the buffered update.
// Assumes the producer keeps hp_valid_i low while hp_buf_i is being rewritten.
module sqw_period #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    input  logic         adv_i,
    input  logic [W-1:0] hp_buf_i,
    input  logic         hp_valid_i,
    output logic [W-1:0] cmp_o,
    output logic [W-1:0] act_o
);
    logic [W-1:0] cmp_q;
    logic [W-1:0] act_q;
    logic [W-1:0] hp_use;

    // Half-period in force for this toggle: buffer if marked valid, else the current one.
    always_comb begin
        hp_use = hp_valid_i ? hp_buf_i : act_q;
    end

    // Seed on start, otherwise advance the compare point by the half-period on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
            act_q <= '0;
        end else if (load_i) begin
            cmp_q <= seed_i;
            act_q <= seed_i;
        end else if (adv_i) begin
            act_q <= hp_use;
            cmp_q <= cmp_q + hp_use;
        end
    end

    assign cmp_o = cmp_q;
    assign act_o = act_q;
endmodule

// File: rtl/sqw_ctrl.sv
// Run/halt sequencer and output flop. It parks the output high whenever the
// generator is not running. Assumes stop_i and en_i are synchronous to clk.
module sqw_ctrl
    import sqw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  logic      stop_i,
    input  logic      hit_i,
    output logic      armed_o,
    output logic      load_o,
    output sq_state_e state_o,
    output logic      wave_o
);
    sq_state_e st_q;
    sq_state_e st_d;
    logic      wave_q;

    // Toggling is allowed only in the run state with enable and no stop.
    always_comb begin
        armed_o = (st_q == SQ_RUN) && en_i && !stop_i;
        load_o  = (st_q == SQ_IDLE) && en_i && !stop_i;
    end

    // Next-state selection; stop wins over everything, halt waits for enable to drop.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE: if (stop_i) st_d = SQ_HALT;
                     else if (en_i) st_d = SQ_RUN;
            SQ_RUN:  if (stop_i) st_d = SQ_HALT;
                     else if (!en_i) st_d = SQ_IDLE;
            SQ_HALT: if (!en_i) st_d = SQ_IDLE;
            default: st_d = SQ_IDLE;
        endcase
    end

    // State register and output level: invert on a hit, otherwise park high when not armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            wave_q <= 1'b1;
        end else begin
            st_q <= st_d;
            if (hit_i)
                wave_q <= ~wave_q;
            else if (st_d != SQ_RUN)
                wave_q <= 1'b1;
        end
    end

    assign state_o = st_q;
    assign wave_o  = wave_q;
endmodule

// File: rtl/sqwave_cmp_gen.sv
// Top of the compare-driven square wave generator. It toggles wave_o each time
// the free-running timer reaches the compare point, then moves the compare
// point forward by the active half-period. Assumes the timer is in the same
// clock domain and tick_i marks each new timer value.
module sqwave_cmp_gen #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         stop_i,
    input  logic [W-1:0] tmr_i,
    input  logic         tick_i,
    input  logic [W-1:0] seed_i,
    input  logic [W-1:0] hp_buf_i,
    input  logic         hp_valid_i,
    output logic         wave_o
);
    import sqw_pkg::*;

    logic         armed;
    logic         load;
    logic         hit;
    logic         running;
    logic [W-1:0] cmp_val;
    logic [W-1:0] act_val;
    sq_state_e    state;

    sqw_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .stop_i  (stop_i),
        .hit_i   (hit),
        .armed_o (armed),
        .load_o  (load),
        .state_o (state),
        .wave_o  (wave_o)
    );

    sqw_match #(.W(W)) u_match (
        .armed_i (armed),
        .tick_i  (tick_i),
        .tmr_i   (tmr_i),
        .cmp_i   (cmp_val),
        .hit_o   (hit)
    );

    sqw_period #(.W(W)) u_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .seed_i     (seed_i),
        .adv_i      (hit),
        .hp_buf_i   (hp_buf_i),
        .hp_valid_i (hp_valid_i),
        .cmp_o      (cmp_val),
        .act_o      (act_val)
    );

    // Run flag for observation by the checker.
    assign running = (state == SQ_RUN);
endmodule

// File: rtl/sqwave_cmp_gen_chk.sv
// Property checker for the square wave generator, attached by bind.
module sqwave_cmp_gen_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en_i,
    input logic         stop_i,
    input logic [W-1:0] tmr_i,
    input logic         tick_i,
    input logic [W-1:0] hp_buf_i,
    input logic         hp_valid_i,
    input logic         wave_o,
    input logic         running,
    input logic [W-1:0] cmp_val,
    input logic [W-1:0] act_val
);
    logic live;
    logic event_hit;
    assign live      = running && en_i && !stop_i;
    assign event_hit = live && tick_i && (tmr_i == cmp_val);

    a_r1_toggle_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        event_hit |=> (wave_o != $past(wave_o)));

    a_r2_advance_compare: assert property (@(posedge clk) disable iff (!rst_n)
        (event_hit && !hp_valid_i) |=> (cmp_val == W'($past(cmp_val) + $past(act_val))));

    a_r3_take_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (event_hit && hp_valid_i) |=> (act_val == $past(hp_buf_i)
                                       && cmp_val == W'($past(cmp_val) + $past(hp_buf_i))));

    a_r4_keep_active: assert property (@(posedge clk) disable iff (!rst_n)
        (event_hit && !hp_valid_i) |=> (act_val == $past(act_val)));

    a_r7_stop_parks_high: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (wave_o && !running));

    a_r8_disable_parks_high: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> wave_o);

    a_r9_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !tick_i) |=> ($stable(wave_o) && $stable(cmp_val)));
endmodule

bind sqwave_cmp_gen sqwave_cmp_gen_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .stop_i     (stop_i),
    .tmr_i      (tmr_i),
    .tick_i     (tick_i),
    .hp_buf_i   (hp_buf_i),
    .hp_valid_i (hp_valid_i),
    .wave_o     (wave_o),
    .running    (running),
    .cmp_val    (cmp_val),
    .act_val    (act_val)
);

// File: tb/sqwave_cmp_gen_tb_top.sv
module sqwave_cmp_gen_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en_i = 1'b0;
    logic         stop_i = 1'b0;
    logic [W-1:0] tmr_i = '0;
    logic         tick_i = 1'b0;
    logic [W-1:0] seed_i = '0;
    logic [W-1:0] hp_buf_i = '0;
    logic         hp_valid_i = 1'b0;
    logic         wave_o;

    int checks = 0;
    int errors = 0;
    int toggles = 0;
    string tag = "R6";

    always #2.5 clk = ~clk;

    sqwave_cmp_gen #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .stop_i(stop_i),
        .tmr_i(tmr_i), .tick_i(tick_i), .seed_i(seed_i),
        .hp_buf_i(hp_buf_i), .hp_valid_i(hp_valid_i), .wave_o(wave_o)
    );

    // Expected behaviour derived from the requirements: 0 idle, 1 run, 2 halt.
    int           m_st;
    logic         m_wave;
    logic [W-1:0] m_cmp;
    logic [W-1:0] m_act;

    function automatic logic [W-1:0] next_hp(logic v, logic [W-1:0] buf_v, logic [W-1:0] act);
        return v ? buf_v : act;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= 0; m_wave <= 1'b1; m_cmp <= '0; m_act <= '0;
        end else begin
            case (m_st)
                0: if (stop_i) m_st <= 2;
                   else if (en_i) begin
                       m_st <= 1; m_cmp <= seed_i; m_act <= seed_i;
                   end
                1: if (stop_i) begin m_st <= 2; m_wave <= 1'b1; end
                   else if (!en_i) begin m_st <= 0; m_wave <= 1'b1; end
                   else if (tick_i && tmr_i == m_cmp) begin
                       m_wave <= ~m_wave;
                       m_act  <= next_hp(hp_valid_i, hp_buf_i, m_act);
                       m_cmp  <= m_cmp + next_hp(hp_valid_i, hp_buf_i, m_act);
                   end
                default: if (!en_i) m_st <= 0;
            endcase
        end
    end

    task automatic check(input logic exp, input string req);
        checks++;
        if (wave_o !== exp) begin
            errors++;
            $display("FAIL %s: wave_o=%b expected=%b at t=%0t", req, wave_o, exp, $time);
        end
    endtask

    // One cycle: compare at the falling edge, then set up inputs for the next rising edge.
    task automatic step(input bit rnd_tick, input bit force_tick);
        @(negedge clk);
        check(m_wave, tag);
        if (m_st == 1 && wave_o != m_wave) toggles += 0;
        if (force_tick || (rnd_tick && ($urandom % 2 == 0))) begin
            tmr_i  = tmr_i + 1'b1;
            tick_i = 1'b1;
        end else begin
            tick_i = 1'b0;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (4) @(negedge clk);
        checks++;
        if (wave_o !== 1'b1) begin
            errors++;
            $display("FAIL R6: wave_o=%b expected=1 after reset", wave_o);
        end
        @(negedge clk) rst_n = 1'b1;

        // R5, R1, R2: start from a seed with a fixed half-period.
        tag = "R5";
        tmr_i = '0; seed_i = 16'd12; en_i = 1'b1;
        for (int i = 0; i < 12; i++) step(1'b0, 1'b1);
        tag = "R1";
        for (int i = 0; i < 400; i++) step(1'b1, 1'b0);

        // R3 and R4: producer rewrites the buffer with valid low, then marks it valid.
        tag = "R3";
        for (int i = 0; i < 3000; i++) begin
            step(1'b1, 1'b0);
            case ($urandom % 16)
                0: begin hp_valid_i = 1'b0; hp_buf_i = W'(3 + $urandom % 28); end
                1: hp_valid_i = 1'b1;
                2: if (!hp_valid_i) hp_buf_i = W'(2 + $urandom % 5);
                default: ;
            endcase
            tag = hp_valid_i ? "R3" : "R4";
        end
        hp_valid_i = 1'b0;

        // R9: timer parked on the compare value with no tick.
        tag = "R9";
        @(negedge clk);
        check(m_wave, tag);
        tmr_i = m_cmp; tick_i = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(m_wave, "R9");
        end
        tick_i = 1'b1;
        @(negedge clk);
        check(m_wave, "R9");
        tick_i = 1'b0;

        // R8: enable drop parks high, then restart.
        tag = "R8";
        en_i = 1'b0;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        tmr_i = '0; seed_i = 16'd7; en_i = 1'b1;
        tag = "R5";
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0);

        // R7: stop while enable stays high; no self-restart.
        tag = "R7";
        stop_i = 1'b1;
        step(1'b1, 1'b0);
        stop_i = 1'b0;
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1);
        en_i = 1'b0;
        step(1'b1, 1'b0);

        // R2 wrap: start near the top of the range and shrink the period at the first toggle.
        tag = "R2";
        tmr_i = 16'hFFF0; seed_i = 16'hFFF8; hp_buf_i = 16'd20; hp_valid_i = 1'b1;
        en_i = 1'b1;
        for (int i = 0; i < 300; i++) step(1'b0, 1'b1);
        hp_valid_i = 1'b0;
        for (int i = 0; i < 300; i++) step(1'b1, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule